// File: doc/BRIEF.md
# GPIO controller with edge-detect interrupts

This block controls sixteen general-purpose pins from a byte-wide register port. The port has an 8-bit address, 8-bit write data, a write strobe, a read strobe and 8-bit read data. The pins form two banks of eight. Each pin has two byte registers:

- An output-control byte sets the pin's direction and the level it drives. Its pad-style bits (open-drain, pull enable, pull select) are only stored.
- An input-control byte returns the synchronized pin level and holds a 2-bit edge-detect mode.

A detected edge sets a per-pin pending bit in the status register of its bank. Software acknowledges by writing ones to that register, so writing back the value it just read clears exactly those pins. A single interrupt line is raised while any pending pin is unmasked in the primary mask registers. A secondary pair of mask registers and a panel byte are plain storage.

The register port and the pin controls are plain strobes and levels. No stream data crosses the block, so there is no valid/ready handshake and no back-pressure. A read is registered: the read data updates on the clock edge where the read strobe is high and holds otherwise.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: Output-control registers sit at 0x2B+k (bank 0, pin k) and 0x3B+k (bank 1, pin 8+k). The whole byte reads back as written. Bit 5 drives `pin_oe` for that pin and bit 0 drives `pin_out`.
- R3: Input-control registers sit at 0x33+k and 0x43+k. A read returns the pin level, after a two-flop synchronizer, in bit 0 and the detect mode in bits 2:1. All other bits read 0, and writes to them are ignored.
- R4: Detect mode 0 ignores edges, 1 flags falling edges, 2 flags rising edges and 3 flags both.
- R5: A flagged edge sets the pin's bit (bit k) in the pending register, at 0x0B for bank 0 and 0x0C for bank 1. A bit stays set until software clears it.
- R6: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R7: If a new edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R8: The primary mask registers are at 0x19 (bank 0) and 0x1A (bank 1). `irq` is high exactly when some pending bit has a clear mask bit. An edge still sets its pending bit while the pin is masked.
- R9: The secondary mask registers at 0x1B and 0x1C read back as written and have no effect on `irq`.
- R10: Address 0x52 is a read/write byte. Reads of unmapped addresses return 0x00.
- R11: `bus_rdata` changes only on a clock edge where `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Pin input levels (asynchronous) |
| pin_out | output | 16 | Value driven on each pin |
| pin_oe | output | 16 | Output enable for each pin |
| irq | output | 1 | Combined unmasked pending interrupt |

## Verification
Every pin is taken through all four detect modes with both a rising and a falling transition. This separates the rising-only, falling-only, both-edge and off behaviours, and it also catches a wrong bank, wrong bit or wrong address offset on any pin.

Each output-control byte gets a distinct pattern, which separates the direction bit from the value bit and shows that the pad bits are only stored. Writing all ones to an input-control register confirms that only the mode bits are kept.

Three timed cases cover the pending logic:
- A clearing write made in the very cycle a new edge lands tells edge-priority apart from clear-priority.
- A clearing write at a quiet time shows that the clear works on its own.
- Mask sweeps over both register pairs tell the gating masks apart from the storage-only ones.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BANKS         = 2;
  localparam int PINS_PER_BANK = 8;
  localparam int NPINS         = BANKS * PINS_PER_BANK;

  localparam int DIR_BIT = 5;
  localparam int VAL_BIT = 0;

  localparam logic [7:0] PANEL_ADDR = 8'h52;

  typedef enum logic [1:0] {
    DET_OFF  = 2'd0,
    DET_FALL = 2'd1,
    DET_RISE = 2'd2,
    DET_BOTH = 2'd3
  } det_mode_e;

  function automatic logic [7:0] ctlo_base(input int b);
    return (b == 0) ? 8'h2B : 8'h3B;
  endfunction

  function automatic logic [7:0] ctli_base(input int b);
    return (b == 0) ? 8'h33 : 8'h43;
  endfunction

  function automatic logic [7:0] stat_addr(input int b);
    return (b == 0) ? 8'h0B : 8'h0C;
  endfunction

  function automatic logic [7:0] mask_addr(input int b);
    return (b == 0) ? 8'h19 : 8'h1A;
  endfunction

  function automatic logic [7:0] maskx_addr(input int b);
    return (b == 0) ? 8'h1B : 8'h1C;
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic [1:0] mode,
  output logic       level,
  output logic       hit
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  logic rise, fall;
  assign rise  = s2_q & ~prev_q;
  assign fall  = ~s2_q & prev_q;
  assign level = s2_q;
  // mode bit 1 selects rising, bit 0 selects falling
  assign hit   = (mode[1] & rise) | (mode[0] & fall);
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int W        = PINS_PER_BANK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   bus_addr,
  input  logic [7:0]   bus_wdata,
  input  logic         bus_wr,
  input  logic [W-1:0] pin_in,
  output logic [7:0]   rd_val,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] mask_q
);
  localparam logic [7:0] CTLO_B = ctlo_base(BANK_IDX);
  localparam logic [7:0] CTLI_B = ctli_base(BANK_IDX);
  localparam logic [7:0] STAT_A = stat_addr(BANK_IDX);
  localparam logic [7:0] MASK_A = mask_addr(BANK_IDX);
  localparam logic [7:0] MSKX_A = maskx_addr(BANK_IDX);

  logic [7:0]   ctlo_q [W];
  logic [1:0]   mode_q [W];
  logic [W-1:0] level, hit;
  logic [W-1:0] maskx_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctlo_q[i] <= '0;
        mode_q[i] <= DET_OFF;
      end else begin
        if (bus_wr && bus_addr == CTLO_B + 8'(i)) ctlo_q[i] <= bus_wdata;
        if (bus_wr && bus_addr == CTLI_B + 8'(i)) mode_q[i] <= bus_wdata[2:1];
      end
    end

    gpio_pin_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in[i]),
      .mode   (mode_q[i]),
      .level  (level[i]),
      .hit    (hit[i])
    );

    assign pin_out[i] = ctlo_q[i][VAL_BIT];
    assign pin_oe[i]  = ctlo_q[i][DIR_BIT];
  end

  logic [W-1:0] clr;
  assign clr = (bus_wr && bus_addr == STAT_A) ? bus_wdata[W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '0;
      maskx_q <= '0;
    end else begin
      // a new edge takes priority over a simultaneous clear
      pend_q <= (pend_q & ~clr) | hit;
      if (bus_wr && bus_addr == MASK_A) mask_q  <= bus_wdata[W-1:0];
      if (bus_wr && bus_addr == MSKX_A) maskx_q <= bus_wdata[W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == STAT_A) rd_val = 8'(pend_q);
    if (bus_addr == MASK_A) rd_val = 8'(mask_q);
    if (bus_addr == MSKX_A) rd_val = 8'(maskx_q);
    for (int i = 0; i < W; i++) begin
      if (bus_addr == CTLO_B + 8'(i)) rd_val = ctlo_q[i];
      if (bus_addr == CTLI_B + 8'(i)) rd_val = {5'b0, mode_q[i], level[i]};
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [7:0]       bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic [7:0]       bank_rd [BANKS];
  logic [NPINS-1:0] pend_all, mask_all;
  logic [7:0]       panel_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gpio_edge_bank #(.BANK_IDX(b), .W(PINS_PER_BANK)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .pin_in    (pin_in  [b*PINS_PER_BANK +: PINS_PER_BANK]),
      .rd_val    (bank_rd[b]),
      .pin_out   (pin_out [b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pin_oe    (pin_oe  [b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pend_q    (pend_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .mask_q    (mask_all[b*PINS_PER_BANK +: PINS_PER_BANK])
    );
  end

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = (bus_addr == PANEL_ADDR) ? panel_q : 8'h00;
    for (int b = 0; b < BANKS; b++) rd_mux = rd_mux | bank_rd[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      panel_q   <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == PANEL_ADDR) panel_q <= bus_wdata;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign irq = |(pend_all & ~mask_all);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] pend_all,
  input logic [NPINS-1:0] mask_all,
  input logic             irq
);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(pin_oe));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(pin_out));

  // R6
  pend_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_all) & ~pend_all)) |-> $past(bus_wr));

  // R8
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_all) |-> !irq);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pend_all  (pend_all),
  .mask_all  (mask_all),
  .irq       (irq)
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl u_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); pin_in[p] = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] ctlo_a(int p); return (p < 8 ? 8'h2B : 8'h3B) + 8'(p % 8); endfunction
  function automatic logic [7:0] ctli_a(int p); return (p < 8 ? 8'h33 : 8'h43) + 8'(p % 8); endfunction
  function automatic logic [7:0] stat_a(int p); return p < 8 ? 8'h0B : 8'h0C; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", pin_oe, 16'h0);
    chk("R1 out", pin_out, 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    rd_reg(8'h0B, d); chk("R1 pend0", 16'(d), 16'h0);
    rd_reg(8'h19, d); chk("R1 mask0", 16'(d), 16'h0);
    rd_reg(8'h52, d); chk("R1 panel", 16'(d), 16'h0);

    // R2 output-control sweep
    for (int p = 0; p < 16; p++) begin
      logic [7:0] pat;
      pat = 8'(p * 37 + 5);
      wr_reg(ctlo_a(p), pat);
      rd_reg(ctlo_a(p), d);
      chk("R2 readback", 16'(d), 16'(pat));
      chk("R2 oe", 16'(pin_oe[p]), 16'(pat[5]));
      chk("R2 out", 16'(pin_out[p]), 16'(pat[0]));
      wr_reg(ctlo_a(p), 8'h00);
    end

    // R3 ignored bits in input-control
    wr_reg(ctli_a(3), 8'hFF);
    rd_reg(ctli_a(3), d); chk("R3 only mode kept", 16'(d), 16'h06);
    wr_reg(ctli_a(3), 8'h00);

    // R4 R5 R6 R8 sweep of pins, modes and edge directions
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] bitv;
        bitv = 8'(1 << (p % 8));
        wr_reg(ctli_a(p), 8'(m << 1));
        wr_reg(8'h0B, 8'hFF); wr_reg(8'h0C, 8'hFF);
        set_pin(p, 1'b1);
        rd_reg(ctli_a(p), d);
        chk("R3 level high", 16'(d), 16'(8'(m << 1) | 8'h01));
        rd_reg(stat_a(p), d);
        chk("R4 rise", 16'(d), (m[1]) ? 16'(bitv) : 16'h0);
        chk("R8 irq rise", 16'(irq), 16'(m[1]));
        wr_reg(stat_a(p), d);
        rd_reg(stat_a(p), d); chk("R6 cleared", 16'(d), 16'h0);
        set_pin(p, 1'b0);
        rd_reg(stat_a(p), d);
        chk("R4 fall", 16'(d), (m[0]) ? 16'(bitv) : 16'h0);
        wr_reg(stat_a(p), 8'hFF);
        wr_reg(ctli_a(p), 8'h00);
      end
    end

    // R5 pending holds; R8 masking; R9 secondary mask has no effect
    wr_reg(ctli_a(10), 8'h06);
    set_pin(10, 1'b1);
    wr_reg(8'h1A, 8'h04);
    repeat (2) @(negedge clk);
    chk("R8 masked irq", 16'(irq), 16'h0);
    rd_reg(8'h0C, d); chk("R8 pend while masked", 16'(d), 16'h04);
    rd_reg(8'h0C, d); chk("R5 still pending", 16'(d), 16'h04);
    wr_reg(8'h1A, 8'h00);
    wr_reg(8'h1B, 8'hFF); wr_reg(8'h1C, 8'hFF);
    @(negedge clk);
    chk("R9 no gating", 16'(irq), 16'h1);
    rd_reg(8'h1C, d); chk("R9 readback", 16'(d), 16'hFF);
    wr_reg(8'h0C, 8'hFB);
    rd_reg(8'h0C, d); chk("R6 zero bit kept", 16'(d), 16'h04);

    // R7 edge lands in the clearing cycle
    @(negedge clk); pin_in[10] = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_addr = 8'h0C; bus_wdata = 8'h04; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd_reg(8'h0C, d); chk("R7 edge wins", 16'(d), 16'h04);
    wr_reg(8'h0C, 8'h04);
    rd_reg(8'h0C, d); chk("R6 quiet clear", 16'(d), 16'h00);
    chk("R8 irq low", 16'(irq), 16'h0);

    // R10 panel and unmapped
    wr_reg(8'h52, 8'hA5);
    rd_reg(8'h52, d); chk("R10 panel", 16'(d), 16'hA5);
    rd_reg(8'h60, d); chk("R10 unmapped", 16'(d), 16'h00);

    // R11 read data holds without a read strobe
    @(negedge clk); bus_addr = 8'h52;
    @(negedge clk); @(negedge clk);
    chk("R11 hold", 16'(bus_rdata), 16'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule